// File: doc/BRIEF.md
# Serial Audio Sign-Split Converter

This block sits between a serial audio source and two pairs of simultaneous-mode current DACs that together form a signed-magnitude converter. It watches a bit clock, a word select and a serial data line. For every channel word it reads the sign bit and keeps it out of the DAC stream. The magnitude bits that follow are sent to the positive-half DAC when the sample is zero or positive, and to the negative-half DAC when it is negative. The half that is not in use is held at its zero-output code, so near a zero crossing only one low bit changes and no full-width code flip occurs.

The source framing is either left-justified or I2S, chosen by a mode input. Once a frame holds both channels, the block shifts out all four lanes (left-minus, left-plus, right-minus, right-plus) in one gated bit-clock burst of `DAC_W` pulses. It then gives a one-cycle latch strobe. The block runs on a fast system clock and detects the serial bit-clock edges as synchronous inputs.

A frame tracker moves through the states PRIME, HUNT and LIVE. On reset it enters PRIME. It leaves PRIME for HUNT on the first bit-clock rise. It moves from HUNT to LIVE on the first word-select edge that begins a left word, and it stays in LIVE. A burst sequencer moves through IDLE, LEAD, SHIFT and END. A launch moves it from IDLE to SHIFT in left-justified mode, or from IDLE to LEAD in I2S mode. It moves from LEAD to SHIFT on the next bit rise. It stays in SHIFT for `DAC_W` bit rises and then moves to END. From END it returns to IDLE on the next bit rise, which also issues the strobe.

Top module: `ssm_splitter`

## Requirements
- R1: While reset is held and in the first cycle after it is released, the output bit clock, all four data lanes and the latch strobe are low. Reset is synchronous and active high.
- R2: With `i2s_mode`=0, a word starts on the first bit-clock rise after a word-select change, and that bit is the sign. Word select high marks the left channel.
- R3: With `i2s_mode`=1, the sign is the second bit after a word-select change. Word select low marks the left channel.
- R4: Each channel's lanes are steered only by that channel's own sign bit, even when the two channels have opposite signs.
- R5: A word whose sign bit is 0 puts its `DAC_W` following bits, MSB first, on that channel's plus lane, and all ones on its minus lane.
- R6: A word whose sign bit is 1 puts its `DAC_W` following bits, MSB first, on that channel's minus lane, and all zeros on its plus lane.
- R7: Each burst has exactly `DAC_W` output bit-clock pulses and carries both channels at once. Data lanes change only when the output clock rises, so they are stable at each falling edge.
- R8: Outside a burst the output bit clock and all four data lanes are low.
- R9: After the last bit of a burst, the latch strobe is high for exactly one system-clock cycle, with the output clock low. It comes on the next serial bit-clock rise.
- R10: The frame whose left word begins a stream is sent during the left word of the following frame. Until such a following left-start edge arrives, no burst and no strobe appear. Every frame that is followed by another frame is sent exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| i2s_mode | input | 1 | 0 = left-justified framing, 1 = I2S framing |
| bclk | input | 1 | Serial audio bit clock |
| ws | input | 1 | Serial audio word select |
| sdata | input | 1 | Serial audio data, MSB first |
| dac_bclk | output | 1 | Gated bit-clock burst for the DACs |
| lm | output | 1 | Left negative-half DAC data |
| lp | output | 1 | Left positive-half DAC data |
| rm | output | 1 | Right negative-half DAC data |
| rp | output | 1 | Right positive-half DAC data |
| dac_latch | output | 1 | One-cycle latch strobe after each burst |

## Verification
The hardest case to reach is in I2S mode, where the sign sits one slot after the word-select edge and the channels have opposite signs in the same frame. A sign taken from the wrong slot, or from the wrong channel, is only seen as a wrong choice between the zero-code lanes and the magnitude lanes. To reach it, the bench drives the same directed frames in both framing modes. These include +max against -max, -1 against +1, and zero against zero. Random words follow, and the bench checks every lane of every burst against its own split of the driven words. A single frame followed by a long run of unchanged word select shows that nothing is sent until the next left-start edge.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

    typedef enum logic [1:0] {
        FR_PRIME,
        FR_HUNT,
        FR_LIVE
    } frame_st_e;

    typedef enum logic [1:0] {
        BS_IDLE,
        BS_LEAD,
        BS_SHIFT,
        BS_END
    } burst_st_e;

    localparam int LANE_MINUS = 0;
    localparam int LANE_PLUS  = 1;
    localparam int LANES      = 4;

endpackage

// File: rtl/ssm_frame.sv
module ssm_frame
    import ssm_pkg::*;
#(
    parameter int POS_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bclk,
    input  logic             ws,
    input  logic             i2s_mode,
    output logic             tick,
    output logic             fall,
    output logic             left_half,
    output logic             launch,
    output logic             capture_en,
    output logic [POS_W-1:0] cur_pos
);

    localparam logic [POS_W-1:0] POS_MAX = '1;

    frame_st_e        st_q, st_d;
    logic             bclk_q;
    logic             ws_last;
    logic [POS_W-1:0] pos_q;
    logic             ws_edge;
    logic             left_start;

    always_comb begin
        tick       = bclk & ~bclk_q;
        fall       = ~bclk & bclk_q;
        ws_edge    = tick && (st_q != FR_PRIME) && (ws != ws_last);
        left_half  = (ws == ~i2s_mode);
        left_start = ws_edge && left_half;
        cur_pos    = ws_edge ? '0 : pos_q;
        launch     = left_start && (st_q == FR_LIVE);
        capture_en = (st_q != FR_PRIME);
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FR_PRIME: if (tick)       st_d = FR_HUNT;
            FR_HUNT:  if (left_start) st_d = FR_LIVE;
            FR_LIVE:                  st_d = FR_LIVE;
            default:                  st_d = FR_PRIME;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= FR_PRIME;
            bclk_q  <= 1'b0;
            ws_last <= 1'b0;
            pos_q   <= POS_MAX;
        end else begin
            st_q   <= st_d;
            bclk_q <= bclk;
            if (tick) begin
                ws_last <= ws;
                pos_q   <= (cur_pos == POS_MAX) ? POS_MAX : cur_pos + 1'b1;
            end
        end
    end

    // R10
    launch_live_chk: assert property (@(posedge clk) disable iff (rst)
        launch |-> $past(st_q != FR_PRIME));

endmodule

// File: rtl/ssm_capture.sv
module ssm_capture #(
    parameter int DAC_W = 16,
    parameter int POS_W = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       tick,
    input  logic                       capture_en,
    input  logic                       left_half,
    input  logic                       ofs,
    input  logic                       sd,
    input  logic [POS_W-1:0]           cur_pos,
    output logic [1:0]                 sign,
    output logic [1:0][DAC_W-1:0]      mag
);

    logic [POS_W-1:0] sign_pos;
    logic [POS_W-1:0] last_pos;
    logic             at_sign;
    logic             at_mag;

    always_comb begin
        sign_pos = POS_W'(ofs);
        last_pos = sign_pos + POS_W'(DAC_W);
        at_sign  = tick && capture_en && (cur_pos == sign_pos);
        at_mag   = tick && capture_en && (cur_pos > sign_pos) && (cur_pos <= last_pos);
    end

    for (genvar ch = 0; ch < 2; ch++) begin : g_chan
        logic mine;
        assign mine = (ch == 0) ? left_half : ~left_half;

        always_ff @(posedge clk) begin
            if (rst) begin
                sign[ch] <= 1'b0;
                mag[ch]  <= '0;
            end else begin
                if (at_sign && mine) sign[ch] <= sd;
                if (at_mag && mine)  mag[ch]  <= {mag[ch][DAC_W-2:0], sd};
            end
        end

        // R4
        sign_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !$stable(sign[ch]) |-> $past(tick && capture_en));
    end

endmodule

// File: rtl/ssm_burst.sv
module ssm_burst
    import ssm_pkg::*;
#(
    parameter int DAC_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  logic                  fall,
    input  logic                  launch,
    input  logic                  ofs,
    input  logic [1:0]            sign,
    input  logic [1:0][DAC_W-1:0] mag,
    output logic                  oclk,
    output logic [LANES-1:0]      data,
    output logic                  latch
);

    localparam int CNT_W = $clog2(DAC_W) + 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DAC_W - 1);

    burst_st_e                   st_q, st_d;
    logic [CNT_W-1:0]            cnt_q;
    logic [LANES-1:0][DAC_W-1:0] lane_src;
    logic [LANES-1:0][DAC_W-1:0] sh_q;

    for (genvar ch = 0; ch < 2; ch++) begin : g_lane
        assign lane_src[2*ch+LANE_MINUS] = sign[ch] ? mag[ch] : '1;
        assign lane_src[2*ch+LANE_PLUS]  = sign[ch] ? '0 : mag[ch];
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BS_IDLE:  if (launch) st_d = ofs ? BS_LEAD : BS_SHIFT;
            BS_LEAD:  if (tick)   st_d = BS_SHIFT;
            BS_SHIFT: if (tick && cnt_q == LAST) st_d = BS_END;
            BS_END:   if (tick)   st_d = BS_IDLE;
            default:              st_d = BS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= BS_IDLE;
            cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == BS_SHIFT && tick) cnt_q <= cnt_q + 1'b1;
            else if (st_q == BS_IDLE)     cnt_q <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            oclk  <= 1'b0;
            data  <= '0;
            latch <= 1'b0;
            sh_q  <= '0;
        end else begin
            latch <= 1'b0;
            if (fall) oclk <= 1'b0;
            if (st_q == BS_IDLE && launch) sh_q <= lane_src;
            if (tick) begin
                if (st_q == BS_SHIFT) begin
                    oclk <= 1'b1;
                    for (int k = 0; k < LANES; k++) begin
                        data[k] <= sh_q[k][DAC_W-1];
                        sh_q[k] <= {sh_q[k][DAC_W-2:0], 1'b0};
                    end
                end else if (st_q == BS_END) begin
                    data  <= '0;
                    latch <= 1'b1;
                end
            end
        end
    end

    logic             oclk_d1;
    logic [CNT_W:0]   rises_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            oclk_d1 <= 1'b0;
            rises_q <= '0;
        end else begin
            oclk_d1 <= oclk;
            if (latch)               rises_q <= '0;
            else if (oclk & ~oclk_d1) rises_q <= rises_q + 1'b1;
        end
    end

    // R9
    latch_single_chk: assert property (@(posedge clk) disable iff (rst)
        latch |=> !latch);

    // R9
    latch_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        latch |-> (!oclk && data == '0));

    // R7
    pulse_count_chk: assert property (@(posedge clk) disable iff (rst)
        latch |-> (rises_q == (CNT_W+1)'(DAC_W)));

    // R7
    fall_stable_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(oclk) |-> $stable(data));

    // R8
    data_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(data) |-> $past(tick));

endmodule

// File: rtl/ssm_splitter.sv
module ssm_splitter
    import ssm_pkg::*;
#(
    parameter int DAC_W = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic i2s_mode,
    input  logic bclk,
    input  logic ws,
    input  logic sdata,
    output logic dac_bclk,
    output logic lm,
    output logic lp,
    output logic rm,
    output logic rp,
    output logic dac_latch
);

    localparam int POS_W = $clog2(DAC_W + 4) + 1;

    logic                  tick;
    logic                  fall;
    logic                  left_half;
    logic                  launch;
    logic                  capture_en;
    logic [POS_W-1:0]      cur_pos;
    logic [1:0]            sign;
    logic [1:0][DAC_W-1:0] mag;
    logic [LANES-1:0]      data;

    ssm_frame #(.POS_W(POS_W)) u_frame (
        .clk        (clk),
        .rst        (rst),
        .bclk       (bclk),
        .ws         (ws),
        .i2s_mode   (i2s_mode),
        .tick       (tick),
        .fall       (fall),
        .left_half  (left_half),
        .launch     (launch),
        .capture_en (capture_en),
        .cur_pos    (cur_pos)
    );

    ssm_capture #(.DAC_W(DAC_W), .POS_W(POS_W)) u_capture (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .capture_en (capture_en),
        .left_half  (left_half),
        .ofs        (i2s_mode),
        .sd         (sdata),
        .cur_pos    (cur_pos),
        .sign       (sign),
        .mag        (mag)
    );

    ssm_burst #(.DAC_W(DAC_W)) u_burst (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .fall   (fall),
        .launch (launch),
        .ofs    (i2s_mode),
        .sign   (sign),
        .mag    (mag),
        .oclk   (dac_bclk),
        .data   (data),
        .latch  (dac_latch)
    );

    assign lm = data[0*2+LANE_MINUS];
    assign lp = data[0*2+LANE_PLUS];
    assign rm = data[1*2+LANE_MINUS];
    assign rp = data[1*2+LANE_PLUS];

endmodule

// File: tb/ssm_splitter_test.sv
module ssm_splitter_test;

    localparam int W    = 16;
    localparam int HALF = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic i2s = 1'b0;
    logic bclk = 1'b0;
    logic ws = 1'b0;
    logic sd = 1'b0;
    logic oclk, lm, lp, rm, rp, lat;

    ssm_splitter #(.DAC_W(W)) uut (
        .clk(clk), .rst(rst), .i2s_mode(i2s), .bclk(bclk), .ws(ws), .sdata(sd),
        .dac_bclk(oclk), .lm(lm), .lp(lp), .rm(rm), .rp(rp), .dac_latch(lat)
    );

    always #2 clk = ~clk;

    typedef struct packed {
        logic [W-1:0] lm, lp, rm, rp;
        logic         mode, sl, sr;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails = 0;
    int   latches = 0;
    bit   done = 0;

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bit_out(input logic w, input logic d);
        @(negedge clk);
        bclk = 1'b0; ws = w; sd = d;
        repeat (3) @(negedge clk);
        bclk = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_half(input logic w, input logic [W:0] word);
        for (int b = 0; b < HALF; b++) begin
            int idx;
            logic d;
            idx = b - (i2s ? 1 : 0);
            d = 1'b0;
            if (idx >= 0 && idx <= W) d = word[W-idx];
            bit_out(w, d);
        end
    endtask

    // driver: pushes the expected split, then sends the frame (left word first)
    task automatic send_frame(input logic [W:0] l, input logic [W:0] r, input bit push);
        exp_t e;
        e.sl = l[W]; e.sr = r[W]; e.mode = i2s;
        e.lp = l[W] ? '0 : l[W-1:0];
        e.lm = l[W] ? l[W-1:0] : '1;
        e.rp = r[W] ? '0 : r[W-1:0];
        e.rm = r[W] ? r[W-1:0] : '1;
        if (push) q.push_back(e);
        send_half(~i2s, l);
        send_half(i2s, r);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) bit_out(i2s, 1'b0);
    endtask

    // monitor
    logic         prev_oclk = 0, prev_lat = 0, in_burst = 0, r8_seen = 0;
    int           bits = 0;
    logic [W-1:0] a_lm, a_lp, a_rm, a_rp;

    always @(negedge clk) begin
        if (rst) begin
            prev_oclk = 0; prev_lat = 0; in_burst = 0; bits = 0; r8_seen = 0;
        end else begin
            if (!prev_oclk && oclk) in_burst = 1;
            if (prev_oclk && !oclk) begin
                a_lm = {a_lm[W-2:0], lm}; a_lp = {a_lp[W-2:0], lp};
                a_rm = {a_rm[W-2:0], rm}; a_rp = {a_rp[W-2:0], rp};
                bits++;
            end
            if (prev_lat && lat) chk(0, "R9 strobe longer than one cycle", 16'd2, 16'd1);
            if (lat) begin
                latches++;
                chk(!oclk, "R9 clock low at strobe", {15'd0, oclk}, 16'd0);
                chk(bits == W, "R7 pulses per burst", bits[W-1:0], W[W-1:0]);
                if (q.size() == 0) begin
                    chk(0, "R10 burst with no pending frame", 16'd1, 16'd0);
                end else begin
                    exp_t e;
                    string mt;
                    e = q.pop_front();
                    mt = e.mode ? "R3" : "R2";
                    chk(a_lp == e.lp, $sformatf("%s/%s/R4 left-plus", mt, e.sl ? "R6" : "R5"), a_lp, e.lp);
                    chk(a_lm == e.lm, $sformatf("%s/%s/R4 left-minus", mt, e.sl ? "R6" : "R5"), a_lm, e.lm);
                    chk(a_rp == e.rp, $sformatf("%s/%s/R4 right-plus", mt, e.sr ? "R6" : "R5"), a_rp, e.rp);
                    chk(a_rm == e.rm, $sformatf("%s/%s/R4 right-minus", mt, e.sr ? "R6" : "R5"), a_rm, e.rm);
                end
                in_burst = 0;
                bits = 0;
            end
            if (!in_burst && !r8_seen && ({lm, lp, rm, rp} != 4'b0)) begin
                r8_seen = 1;
                chk(0, "R8 data outside burst", {12'd0, lm, lp, rm, rp}, 16'd0);
            end
            prev_oclk = oclk;
            prev_lat = lat;
        end
    end

    task automatic run_mode(input logic m);
        int n0;
        rst = 1'b1; i2s = m; bclk = 1'b0; ws = m; sd = 1'b0;
        repeat (6) @(negedge clk);
        chk({oclk, lm, lp, rm, rp, lat} == 6'b0, "R1 outputs during reset", {10'd0, oclk, lm, lp, rm, rp, lat}, 16'd0);
        rst = 1'b0;
        @(negedge clk);
        chk({oclk, lm, lp, rm, rp, lat} == 6'b0, "R1 outputs after reset", {10'd0, oclk, lm, lp, rm, rp, lat}, 16'd0);
        idle(3);
        n0 = latches;
        send_frame(17'h0_1234, 17'h1_8765, 1);
        idle(25);
        chk(latches == n0 && !oclk, "R10 no burst before next left start", latches[W-1:0], n0[W-1:0]);
        send_frame(17'h0_0000, 17'h0_0000, 1);
        send_frame(17'h0_FFFF, 17'h1_0000, 1);
        send_frame(17'h1_FFFF, 17'h0_0001, 1);
        send_frame(17'h0_0001, 17'h1_FFFE, 1);
        for (int i = 0; i < 6; i++) begin
            logic [W:0] l, r;
            l = W'($urandom) | ((W+1)'($urandom & 1) << W);
            r = W'($urandom) | ((W+1)'($urandom & 1) << W);
            send_frame(l, r, 1);
        end
        send_frame(17'h0_0000, 17'h0_0000, 0);
        idle(4);
        chk(q.size() == 0, "R10 every frame sent once", q.size(), 16'd0);
    endtask

    initial begin
        run_mode(1'b0);
        run_mode(1'b1);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #600000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL R10 watchdog: got running expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule